// File: doc/BRIEF.md
# Multi-line transmit DMA scheduler

This block feeds the transmitters of a group of serial lines (16 by default) straight from memory, one byte at a time. Each line owns a start-address register and a byte-count register. Software reaches them through a line-select field held in the control/status register. The count is loaded as the two's-complement negative of the number of bytes to send. Hardware advances both registers after every byte. The transfer ends when the count reaches zero.

Software starts a line by setting that line's bit in the active register. The scheduler then serves the active lines in turn, skipping any line whose transmitter is not ready. It keeps a single memory request in flight. The fetched byte goes out together with a one-cycle load strobe for the chosen line. When a line finishes, its active bit clears on its own and a shared transmit-done flag is set, and that flag can drive an interrupt. A memory error response is latched in a sticky flag and ends the transfer of the line concerned. A break register forces a continuous break on selected lines. A master-clear bit returns every register to zero.

Top module: `txdma_sched`

## Requirements
- R1: Register offsets on `reg_sel` are 0 control/status, 1 address, 2 count, 3 active, 4 break. Control/status bits 3:0 name the line whose address and count registers offsets 1 and 2 reach, for both writes and reads.
- R2: Every accepted fetch (`mem_ack` with no `mem_err`) drives `mem_addr` from the current address of the line being served. In that same cycle the fetched byte appears on `tx_data` with a one-cycle `tx_load` pulse on that line only. The line's address then rises by one and its count rises by one.
- R3: A write to the active register sets the lines whose data bits are 1; 0 bits have no effect. A line's active bit clears by itself once the byte that brings its count to zero has been fetched.
- R4: A line that is active while its count is zero finishes without any fetch: its active bit clears and the transmit-done flag is set.
- R5: Any line finishing sets control/status bit 15. `irq_tx` equals bit 15 AND bit 13. A control/status write with bit 15 = 0 clears the flag, and one with bit 15 = 1 leaves it as it was.
- R6: Writing a count of all ones to an active line makes that line finish after exactly one more byte. That byte is sent as soon as its transmitter is ready.
- R7: A fetch answered with `mem_err` sets control/status bit 10 and gives no `tx_load`. It leaves the line's address and count unchanged, clears the line's active bit and sets bit 15. Writing 1 to bit 8 clears bit 10.
- R8: A control/status write with bit 11 set clears every register: control/status, active, break, and all addresses and counts. It also drops any memory request.
- R9: Control/status bits 13, 12 and 6 are writable enables that read back as written. Bits 14, 9, 7 and 5:4, and the action bits 11 and 8, read as zero. Bit 10 cannot be written.
- R10: The lines eligible for service are those that are active, ready and have a nonzero count. After line k is served, the next one is the first eligible line after k in cyclic order. Only one request is outstanding at a time, and `mem_req` with its address holds steady until `mem_ack` or `mem_err`.
- R11: `tx_break` mirrors the break register at offset 4, which reads back as written.
- R12: No fetch is made for a line whose `tx_ready` is low. Its transfer stays pending until ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req | output | 1 | Byte fetch request |
| mem_addr | output | AW | Fetch address |
| mem_ack | input | 1 | Fetch completed, data valid |
| mem_err | input | 1 | Fetch failed (no memory at address) |
| mem_rdata | input | 8 | Fetched byte |
| tx_ready | input | NLINES | Per-line transmitter ready |
| tx_load | output | NLINES | Per-line byte load strobe |
| tx_data | output | 8 | Byte for the strobed transmitter |
| tx_break | output | NLINES | Per-line break drive |
| irq_tx | output | 1 | Transmit-done interrupt request |

## Verification
The bench sweeps all sixteen line-select values and reads back each line's address and count. A decoder that aliased lines would return a neighbour's value there. It predicts the cyclic service order of three lines that start in a single write, counting from the last line served. A scheduler that reset its pointer or used fixed priority would then send bytes in the wrong sequence.

It also covers three ways a line can end early: a count rewritten to all ones while the line waits and while it runs, an active line with a zero count, and an error response. A design that wrapped the count, fetched for a zero count, or kept fetching after an error would send extra bytes or never clear the active bit. A master clear issued in the middle of a transfer must stop all further loads.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
   // register offsets on reg_sel
   localparam logic [2:0] RS_CSR  = 3'd0;
   localparam logic [2:0] RS_ADDR = 3'd1;
   localparam logic [2:0] RS_CNT  = 3'd2;
   localparam logic [2:0] RS_ACT  = 3'd3;
   localparam logic [2:0] RS_BRK  = 3'd4;
   // control/status bit positions
   localparam int CSR_TXF    = 15;
   localparam int CSR_TIE    = 13;
   localparam int CSR_SIE    = 12;
   localparam int CSR_MCLR   = 11;
   localparam int CSR_NXM    = 10;
   localparam int CSR_NXMCLR = 8;
   localparam int CSR_RIE    = 6;
endpackage

// File: rtl/txdma_rr_arb.sv
module txdma_rr_arb #(
   parameter int N = 16,
   localparam int LW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [N-1:0]  req,
   input  logic          take,
   output logic          gnt_vld,
   output logic [LW-1:0] gnt_idx
);
   logic [LW-1:0] ptr;

   // search starts at ptr; lowest offset wins, so scan downwards
   always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[LW'(ptr + LW'(k))]) begin
            gnt_vld = 1'b1;
            gnt_idx = LW'(ptr + LW'(k));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr <= '0;
      else if (clr)        ptr <= '0;
      else if (take)       ptr <= LW'(gnt_idx + 1'b1);
   end
endmodule

// File: rtl/txdma_line_bank.sv
module txdma_line_bank #(
   parameter int NLINES = 16,
   parameter int AW = 16,
   parameter int CW = 16,
   localparam int LW = $clog2(NLINES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic [LW-1:0]                cpu_line,
   input  logic                         cpu_addr_we,
   input  logic                         cpu_cnt_we,
   input  logic [15:0]                  cpu_wdata,
   input  logic                         hw_step,
   input  logic [LW-1:0]                hw_line,
   output logic [NLINES-1:0][AW-1:0]    addr_o,
   output logic [NLINES-1:0][CW-1:0]    cnt_o
);
   for (genvar g = 0; g < NLINES; g++) begin : g_line
      logic cpu_hit, hw_hit;
      assign cpu_hit = (cpu_line == LW'(g));
      assign hw_hit  = hw_step && (hw_line == LW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_o[g] <= '0;
            cnt_o[g]  <= '0;
         end else if (clr) begin
            addr_o[g] <= '0;
            cnt_o[g]  <= '0;
         end else begin
            // software writes take precedence over the hardware step
            if (cpu_addr_we && cpu_hit) addr_o[g] <= cpu_wdata[AW-1:0];
            else if (hw_hit)            addr_o[g] <= addr_o[g] + 1'b1;
            if (cpu_cnt_we && cpu_hit)  cnt_o[g] <= cpu_wdata[CW-1:0];
            else if (hw_hit && cnt_o[g] != '0) cnt_o[g] <= cnt_o[g] + 1'b1;
         end
      end
   end
endmodule

// File: rtl/txdma_sched.sv
module txdma_sched
   import txdma_pkg::*;
#(
   parameter int NLINES = 16,
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [7:0]        mem_rdata,
   input  logic [NLINES-1:0] tx_ready,
   output logic [NLINES-1:0] tx_load,
   output logic [7:0]        tx_data,
   output logic [NLINES-1:0] tx_break,
   output logic              irq_tx
);
   localparam int LW = $clog2(NLINES);

   if (NLINES < 2 || NLINES > 16 || (1 << LW) != NLINES) begin : g_bad_lines
      $error("NLINES must be a power of two from 2 to 16");
   end
   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("AW must lie in 2..16");
   end
   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("CW must lie in 2..16");
   end

   logic [NLINES-1:0] act, brk;
   logic [LW-1:0]     lsel, cur;
   logic              busy, txf, tie, sie, rie, nxm;
   logic [NLINES-1:0][AW-1:0] addr_v;
   logic [NLINES-1:0][CW-1:0] cnt_v;
   logic [NLINES-1:0] cnt_zero, eligible, cur_mask, zdone, fin_mask, act_set;
   logic              gnt_vld, take, xfer_ok, xfer_bad, last_byte;
   logic [LW-1:0]     gnt_idx;
   logic              csr_hit, mclr, csr_we;

   assign csr_hit = reg_wr && (reg_sel == RS_CSR);
   assign mclr    = csr_hit && reg_wdata[CSR_MCLR];
   assign csr_we  = csr_hit && !reg_wdata[CSR_MCLR];

   for (genvar g = 0; g < NLINES; g++) begin : g_zero
      assign cnt_zero[g] = (cnt_v[g] == '0);
   end

   assign cur_mask  = busy ? (NLINES'(1) << cur) : '0;
   assign eligible  = act & tx_ready & ~cnt_zero;
   assign zdone     = act & cnt_zero & ~cur_mask;
   assign xfer_ok   = busy && mem_ack && !mem_err;
   assign xfer_bad  = busy && mem_err;
   assign last_byte = (cnt_v[cur] == '1) || (cnt_v[cur] == '0);
   assign fin_mask  = ((xfer_ok && last_byte) || xfer_bad) ? cur_mask : '0;
   assign act_set   = (reg_wr && reg_sel == RS_ACT) ? reg_wdata[NLINES-1:0] : '0;
   assign take      = !busy && gnt_vld;

   txdma_rr_arb #(.N(NLINES)) u_arb (
      .clk(clk), .rst_n(rst_n), .clr(mclr), .req(eligible),
      .take(take), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
   );

   txdma_line_bank #(.NLINES(NLINES), .AW(AW), .CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(mclr), .cpu_line(lsel),
      .cpu_addr_we(reg_wr && reg_sel == RS_ADDR),
      .cpu_cnt_we(reg_wr && reg_sel == RS_CNT),
      .cpu_wdata(reg_wdata), .hw_step(xfer_ok), .hw_line(cur),
      .addr_o(addr_v), .cnt_o(cnt_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; cur <= '0; act <= '0; brk <= '0; lsel <= '0;
         txf <= 1'b0; tie <= 1'b0; sie <= 1'b0; rie <= 1'b0; nxm <= 1'b0;
      end else if (mclr) begin
         busy <= 1'b0; cur <= '0; act <= '0; brk <= '0; lsel <= '0;
         txf <= 1'b0; tie <= 1'b0; sie <= 1'b0; rie <= 1'b0; nxm <= 1'b0;
      end else begin
         if (take) begin
            busy <= 1'b1;
            cur  <= gnt_idx;
         end else if (xfer_ok || xfer_bad) begin
            busy <= 1'b0;
         end
         act <= (act & ~(fin_mask | zdone)) | act_set;
         if (reg_wr && reg_sel == RS_BRK) brk <= reg_wdata[NLINES-1:0];
         if (csr_we) begin
            lsel <= reg_wdata[LW-1:0];
            tie  <= reg_wdata[CSR_TIE];
            sie  <= reg_wdata[CSR_SIE];
            rie  <= reg_wdata[CSR_RIE];
         end
         // completion set wins over a same-cycle software clear
         if (|(fin_mask | zdone))                  txf <= 1'b1;
         else if (csr_we && !reg_wdata[CSR_TXF])   txf <= 1'b0;
         if (xfer_bad)                             nxm <= 1'b1;
         else if (csr_we && reg_wdata[CSR_NXMCLR]) nxm <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         RS_CSR: begin
            reg_rdata[LW-1:0]    = lsel;
            reg_rdata[CSR_RIE]   = rie;
            reg_rdata[CSR_NXM]   = nxm;
            reg_rdata[CSR_SIE]   = sie;
            reg_rdata[CSR_TIE]   = tie;
            reg_rdata[CSR_TXF]   = txf;
         end
         RS_ADDR: reg_rdata[AW-1:0]     = addr_v[lsel];
         RS_CNT:  reg_rdata[CW-1:0]     = cnt_v[lsel];
         RS_ACT:  reg_rdata[NLINES-1:0] = act;
         RS_BRK:  reg_rdata[NLINES-1:0] = brk;
         default: reg_rdata = '0;
      endcase
   end

   assign mem_req  = busy;
   assign mem_addr = addr_v[cur];
   assign tx_load  = xfer_ok ? cur_mask : '0;
   assign tx_data  = mem_rdata;
   assign tx_break = brk;
   assign irq_tx   = txf && tie;
endmodule

// File: rtl/txdma_sched_chk.sv
module txdma_sched_chk
   import txdma_pkg::*;
#(
   parameter int NLINES = 16,
   parameter int AW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        reg_sel,
   input logic              reg_wr,
   input logic [15:0]       reg_wdata,
   input logic              mem_req,
   input logic [AW-1:0]     mem_addr,
   input logic              mem_ack,
   input logic              mem_err,
   input logic [NLINES-1:0] tx_load,
   input logic [NLINES-1:0] tx_break,
   input logic              irq_tx
);
   logic mclr_w;
   assign mclr_w = reg_wr && (reg_sel == RS_CSR) && reg_wdata[CSR_MCLR];

   // R2
   load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_load));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !mem_err && !mclr_w) |=> (mem_req && $stable(mem_addr)));

   // R10
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && (mem_ack || mem_err)) |=> !mem_req);

   // R7
   err_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_err |-> (tx_load == '0));

   // R8
   mclr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr_w |=> (!mem_req && !irq_tx && tx_break == '0));

   // R11
   brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && (reg_sel == RS_BRK || mclr_w)) |=> $stable(tx_break));
endmodule

bind txdma_sched txdma_sched_chk #(.NLINES(NLINES), .AW(AW)) u_chk (.*);

// File: tb/txdma_sched_test.sv
`timescale 1ns/100ps
module txdma_sched_test;
   import txdma_pkg::*;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        mem_req, mem_ack, mem_err;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata, tx_data;
   logic [N-1:0] tx_ready = '0;
   logic [N-1:0] tx_load, tx_break;
   logic        irq_tx;
   logic [3:0]  wait_cfg = 4'd0;
   logic [3:0]  wcnt = 4'd0;

   int vecs = 0, fails = 0;
   bit done_flag = 1'b0;
   int log_n = 0;
   int log_line [1024];
   logic [15:0] log_addr [1024];
   logic [7:0]  log_data [1024];

   always #2.5 clk = ~clk;

   txdma_sched uut (.*);

   // memory model: fixed wait, error above 0xF000
   always_ff @(posedge clk) begin
      if (!mem_req || mem_ack || mem_err) wcnt <= 4'd0;
      else wcnt <= wcnt + 4'd1;
   end
   assign mem_err   = mem_req && (wcnt == wait_cfg) && (mem_addr[15:12] == 4'hF);
   assign mem_ack   = mem_req && (wcnt == wait_cfg) && (mem_addr[15:12] != 4'hF);
   assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

   // record every load strobe mid-cycle
   always @(negedge clk) begin
      if (tx_load != '0 && log_n < 1024) begin
         for (int i = 0; i < N; i++)
            if (tx_load[i]) log_line[log_n] = i;
         log_addr[log_n] = mem_addr;
         log_data[log_n] = tx_data;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] got, input logic [31:0] exp);
      vecs++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", rq, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [15:0] d);
      @(posedge clk); #1;
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [15:0] v);
      @(posedge clk); #1;
      reg_sel = s; reg_wr = 1'b0;
      #1 v = reg_rdata;
   endtask

   task automatic prog(input int line, input logic [15:0] a, input logic [15:0] c, input logic [15:0] hi);
      wr(RS_CSR, hi | 16'(line));
      wr(RS_ADDR, a);
      wr(RS_CNT, c);
   endtask

   task automatic wait_clear(input logic [15:0] mask);
      logic [15:0] v;
      for (int k = 0; k < 4000; k++) begin
         rd(RS_ACT, v);
         if ((v & mask) == 0) break;
      end
   endtask

   function automatic int loads_of(input int line, input int from);
      int n = 0;
      for (int i = from; i < log_n; i++) if (log_line[i] == line) n++;
      return n;
   endfunction

   // R2: addresses and bytes of one line's loads since 'from'
   task automatic chk_stream(input int line, input int from, input logic [15:0] a0);
      logic [15:0] a = a0;
      for (int i = from; i < log_n; i++) begin
         if (log_line[i] == line) begin
            chk(log_addr[i] == a, "R2 fetch address", log_addr[i], a);
            chk(log_data[i] == (a[7:0] ^ 8'hA5), "R2 byte on tx_data", log_data[i], a[7:0] ^ 8'hA5);
            a = a + 16'd1;
         end
      end
   endtask

   initial begin
      logic [15:0] v;
      int base, n0, last, exp_line, idx;
      int rem [N];
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      for (int s = 0; s < 5; s++) begin
         rd(3'(s), v);
         chk(v == 0, "R8 reset register value", v, 0);
      end
      chk(!irq_tx && !mem_req && tx_load == 0, "R5 reset outputs idle", {irq_tx, mem_req}, 0);

      // R1: line-select sweep
      for (int l = 0; l < N; l++) prog(l, 16'h1000 + 16'(l * 16'h37), ~16'(l), 16'h0);
      for (int l = 0; l < N; l++) begin
         wr(RS_CSR, 16'(l));
         rd(RS_ADDR, v);
         chk(v == 16'h1000 + 16'(l * 16'h37), "R1 address readback", v, 16'h1000 + 16'(l * 16'h37));
         rd(RS_CNT, v);
         chk(v == ~16'(l), "R1 count readback", v, ~16'(l));
      end

      // R9: enables and reserved bits
      wr(RS_CSR, 16'hB7FF);
      rd(RS_CSR, v);
      chk(v == 16'h304F, "R9 control/status readback", v, 16'h304F);

      // R2 R3 R5: single line
      tx_ready = '1;
      base = log_n;
      prog(3, 16'h0200, 16'hFFFB, 16'h2000);
      wr(RS_ACT, 16'h0008);
      wait_clear(16'h0008);
      chk(loads_of(3, base) == 5, "R3 five bytes then stop", loads_of(3, base), 5);
      chk_stream(3, base, 16'h0200);
      rd(RS_ADDR, v); chk(v == 16'h0205, "R2 address advanced", v, 16'h0205);
      rd(RS_CNT, v);  chk(v == 16'h0000, "R3 count reached zero", v, 0);
      rd(RS_CSR, v);  chk(v == 16'hA003, "R5 done flag set", v, 16'hA003);
      chk(irq_tx == 1'b1, "R5 irq with enable", irq_tx, 1);
      wr(RS_CSR, 16'hA003);
      rd(RS_CSR, v);  chk(v == 16'hA003, "R5 writing 1 keeps flag", v, 16'hA003);
      wr(RS_CSR, 16'h2003);
      rd(RS_CSR, v);  chk(v == 16'h2003, "R5 writing 0 clears flag", v, 16'h2003);
      chk(irq_tx == 1'b0, "R5 irq dropped", irq_tx, 0);

      // R10: cyclic order across three lines, slow memory
      wait_cfg = 4'd2;
      prog(2, 16'h2000, 16'hFFFD, 16'h0);
      prog(5, 16'h2100, 16'hFFFD, 16'h0);
      prog(9, 16'h2200, 16'hFFFD, 16'h0);
      last = log_line[log_n - 1];
      base = log_n;
      wr(RS_ACT, 16'h0224);
      wait_clear(16'h0224);
      for (int i = 0; i < N; i++) rem[i] = 0;
      rem[2] = 3; rem[5] = 3; rem[9] = 3;
      idx = base;
      for (int step = 0; step < 9; step++) begin
         exp_line = -1;
         for (int k = 1; k <= N && exp_line < 0; k++)
            if (rem[(last + k) % N] > 0) exp_line = (last + k) % N;
         rem[exp_line]--;
         last = exp_line;
         chk(idx < log_n && log_line[idx] == exp_line, "R10 service order", log_line[idx], exp_line);
         idx++;
      end
      chk(log_n - base == 9, "R10 total bytes", log_n - base, 9);
      chk_stream(5, base, 16'h2100);
      rd(RS_CSR, v);
      chk(v[15] == 1'b1 && irq_tx == 1'b0, "R5 flag without enable", {v[15], irq_tx}, 2);

      // R12 R3: ready gating, zero writes to active ignored
      wait_cfg = 4'd0;
      tx_ready[6] = 1'b0;
      prog(6, 16'h3000, 16'hFFFE, 16'h0);
      prog(7, 16'h3100, 16'hFFFE, 16'h0);
      base = log_n;
      wr(RS_ACT, 16'h00C0);
      repeat (30) @(posedge clk);
      wr(RS_ACT, 16'h0000);
      rd(RS_ACT, v);
      chk(v == 16'h0040, "R3 zero bits leave active unchanged", v, 16'h0040);
      chk(loads_of(6, base) == 0, "R12 no fetch while not ready", loads_of(6, base), 0);
      chk(loads_of(7, base) == 2, "R12 other line served", loads_of(7, base), 2);
      #1 tx_ready[6] = 1'b1;
      wait_clear(16'h0040);
      chk(loads_of(6, base) == 2, "R12 line served after ready", loads_of(6, base), 2);
      chk_stream(6, base, 16'h3000);

      // R6: flush a waiting line
      tx_ready[8] = 1'b0;
      prog(8, 16'h0300, 16'hFF9C, 16'h0);
      base = log_n;
      wr(RS_ACT, 16'h0100);
      repeat (10) @(posedge clk);
      wr(RS_CNT, 16'hFFFF);
      #1 tx_ready[8] = 1'b1;
      wait_clear(16'h0100);
      chk(loads_of(8, base) == 1, "R6 exactly one byte after flush", loads_of(8, base), 1);
      rd(RS_CNT, v); chk(v == 0, "R6 count zero after flush", v, 0);

      // R6: flush a running line
      wait_cfg = 4'd1;
      prog(10, 16'h0400, 16'hFC18, 16'h0);
      base = log_n;
      wr(RS_ACT, 16'h0400);
      for (int k = 0; k < 200 && loads_of(10, base) < 5; k++) @(posedge clk);
      wr(RS_CNT, 16'hFFFF);
      n0 = loads_of(10, base);
      wait_clear(16'h0400);
      chk(loads_of(10, base) - n0 <= 1, "R6 at most one byte after running flush", loads_of(10, base) - n0, 1);
      chk(loads_of(10, base) >= 5 && loads_of(10, base) < 10, "R6 running flush stopped", loads_of(10, base), 6);
      chk_stream(10, base, 16'h0400);
      rd(RS_CNT, v); chk(v == 0, "R6 running count zero", v, 0);

      // R4: zero count completes without fetch
      wait_cfg = 4'd0;
      prog(11, 16'h0500, 16'h0000, 16'h0);
      base = log_n;
      wr(RS_ACT, 16'h0800);
      repeat (5) @(posedge clk);
      rd(RS_ACT, v);
      chk(v == 0, "R4 zero count clears active", v, 0);
      chk(loads_of(11, base) == 0, "R4 no bytes sent", loads_of(11, base), 0);
      rd(RS_CSR, v); chk(v[15] == 1'b1, "R4 done flag", v, 16'h800B);

      // R7: error response
      prog(12, 16'hF000, 16'hFFFC, 16'h0);
      base = log_n;
      wr(RS_ACT, 16'h1000);
      wait_clear(16'h1000);
      chk(log_n == base, "R7 no load on error", log_n - base, 0);
      rd(RS_CSR, v); chk(v == 16'h840C, "R7 error and done flags", v, 16'h840C);
      rd(RS_ADDR, v); chk(v == 16'hF000, "R7 address unchanged", v, 16'hF000);
      rd(RS_CNT, v); chk(v == 16'hFFFC, "R7 count unchanged", v, 16'hFFFC);
      wr(RS_CSR, 16'h010C);
      rd(RS_CSR, v); chk(v == 16'h000C, "R7 error flag cleared", v, 16'h000C);

      // R11: break register
      wr(RS_BRK, 16'hA5C3);
      #1 chk(tx_break == 16'hA5C3, "R11 break outputs", tx_break, 16'hA5C3);
      rd(RS_BRK, v); chk(v == 16'hA5C3, "R11 break readback", v, 16'hA5C3);
      wr(RS_CSR, 16'h0001);
      #1 chk(tx_break == 16'hA5C3, "R11 break held", tx_break, 16'hA5C3);

      // R8: master clear mid-transfer
      wait_cfg = 4'd1;
      prog(13, 16'h0600, 16'hFFCE, 16'h2000);
      base = log_n;
      wr(RS_ACT, 16'h2000);
      for (int k = 0; k < 200 && loads_of(13, base) < 3; k++) @(posedge clk);
      wr(RS_CSR, 16'h0800);
      n0 = log_n;
      chk(!mem_req && !irq_tx && tx_break == 0, "R8 outputs quiet", {mem_req, irq_tx}, 0);
      for (int s = 0; s < 5; s++) begin
         rd(3'(s), v);
         chk(v == 0, "R8 register cleared", v, 0);
      end
      wr(RS_CSR, 16'h000D);
      rd(RS_ADDR, v); chk(v == 0, "R8 address cleared", v, 0);
      rd(RS_CNT, v); chk(v == 0, "R8 count cleared", v, 0);
      repeat (20) @(posedge clk);
      chk(log_n == n0, "R8 no loads after clear", log_n - n0, 0);

      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs + 1, fails + 1);
         $finish;
      end
   end
endmodule